// File: doc/BRIEF.md
# Two-Step Converter Digital Correction

This block is the digital back end of an 8-bit two-step flash converter that has two time-interleaved channels, A and B. Each channel first resolves a coarse thermometer word and then a fine thermometer word. For the coarse word, the block removes isolated bubbles and encodes the result into the upper 4 bits. It then drives that code out as the fine-reference select for the channel's fine phase. For the fine word, it removes bubbles the same way and resolves the lower 4 bits.

The fine word has one extra comparator just below the selected sub-range and one just above it. When either of them shows that the coarse decision was one step off, the block shifts the merged code across the sub-range boundary. The merged code saturates at 0 and 255.

Conversion starts are accepted strictly in the order A, B, A, B. The two channels' results therefore leave on a single sample port in that same alternating order, each with a valid strobe and a fixed latency.

Top module: `adc2s_corr`

## Requirements
- R1: Coarse bubble removal. Each bit of the 15-bit coarse word (bit j is the comparator at level j+1) is replaced by the majority of itself and its two neighbours. A constant 1 is assumed below bit 0 and a constant 0 above bit 14. An isolated flipped bit at least 3 positions below, or at least 2 positions above, the first 0 of the true word leaves the code unchanged.
- R2: The coarse code is the index of the highest 1 in the corrected word plus one, or 0 if there is none. It appears on that channel's `fsel_*` after the clock edge that accepts the start. It holds its value until the channel's next accepted start.
- R3: The fine word is 17 bits. Bit 0 is the comparator at the sub-range base, bits 1..15 are the fine levels, and bit 16 is the comparator one full sub-range up. The fine word is sampled on the edge after the accepted start and corrected with the same majority rule as the coarse word.
- R4: When corrected bit 0 is 1 and corrected bit 16 is 0, the result is 16·coarse plus the fine code. The fine code is the index of the highest 1 among bits 1..15.
- R5: When corrected bit 0 is 0 (under-range) and bit 16 is 0, the result is 16·coarse − 1, saturating at 0.
- R6: When corrected bit 16 is 1 (over-range), the result is 16·coarse + 16, saturating at 255. This case takes precedence over R5.
- R7: A start is accepted only on the channel whose turn it is. The turn begins at A and toggles on each accepted start. A start on the other channel is ignored: it changes neither `fsel_*` nor the sample stream.
- R8: An accepted start sampled at edge N makes `smp_vld` high for one cycle after edge N+2, carrying the result. `smp_chan` is 0 for A and 1 for B.
- R9: Successive valid samples alternate between channel A and channel B.
- R10: A synchronous active-high reset clears the fine selects, drops every conversion in flight, deasserts `smp_vld` and gives the next turn to channel A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_a | input | 1 | Conversion start request, channel A |
| crs_a | input | 15 | Coarse comparator word, channel A |
| fin_a | input | 17 | Fine comparator word with range bits, channel A |
| start_b | input | 1 | Conversion start request, channel B |
| crs_b | input | 15 | Coarse comparator word, channel B |
| fin_b | input | 17 | Fine comparator word with range bits, channel B |
| fsel_a | output | 4 | Fine sub-range select, channel A |
| fsel_b | output | 4 | Fine sub-range select, channel B |
| smp_vld | output | 1 | Sample valid strobe |
| smp_code | output | 8 | Corrected 8-bit sample |
| smp_chan | output | 1 | Channel that produced the sample (0 = A) |

## Verification
Each kind of internal fault shows at the ports on a known cycle:
- A bad coarse encoding or vote appears on `fsel_*` one edge after the start.
- A faulty fine vote or range correction appears two edges later as a sample off by one LSB or by a whole sub-range near the boundaries.
- A corrupt turn register appears as a missing, extra or mislabelled `smp_vld` pulse three cycles after the start.

The ramp covers every code and both clamping ends, with and without off-by-one coarse choices. Random starts that are out of turn, simultaneous or spaced by gaps test the acceptance order.

// File: rtl/adc2s_pkg.sv
package adc2s_pkg;

  localparam int ADC_C_BITS = 4;
  localparam int ADC_F_BITS = 4;

  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } adc_chan_e;

  function automatic int clamp_int(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/adc2s_vote.sv
module adc2s_vote #(
  parameter int N = 15
) (
  input  logic [N-1:0] raw,
  output logic [N-1:0] fixed
);

  // ext[0] is the virtual 1 below the word, ext[N+1] the virtual 0 above
  logic [N+1:0] ext;
  assign ext = {1'b0, raw, 1'b1};

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign fixed[i] = (ext[i] & ext[i+1]) | (ext[i] & ext[i+2]) | (ext[i+1] & ext[i+2]);
  end

  // R1 / R3: a clean thermometer word passes through untouched
  always_comb begin
    if (((raw + 1'b1) & raw) == '0) begin
      vote_clean_chk: assert (fixed == raw);
    end
  end

endmodule

// File: rtl/adc2s_coarse.sv
module adc2s_coarse #(
  parameter int CW = adc2s_pkg::ADC_C_BITS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc,
  input  logic [(1<<CW)-2:0]      th_raw,
  output logic                    c_vld_q,
  output logic [CW-1:0]           code_q
);

  localparam int CN = (1 << CW) - 1;

  logic [CN-1:0] th_fix;
  logic [CW-1:0] code_w;

  adc2s_vote #(.N(CN)) vote_i (
    .raw   (th_raw),
    .fixed (th_fix)
  );

  function automatic logic [CW-1:0] top_one(input logic [CN-1:0] v);
    logic [CW-1:0] p;
    p = '0;
    for (int i = 0; i < CN; i++) begin
      if (v[i]) p = CW'(i + 1);
    end
    return p;
  endfunction

  assign code_w = top_one(th_fix);

  always_ff @(posedge clk) begin
    if (rst) begin
      c_vld_q <= 1'b0;
      code_q  <= '0;
    end else begin
      c_vld_q <= acc;
      if (acc) code_q <= code_w;
    end
  end

  // R2
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(code_q));

  // R2
  code_load_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> c_vld_q);

endmodule

// File: rtl/adc2s_fine.sv
module adc2s_fine #(
  parameter int CW = adc2s_pkg::ADC_C_BITS,
  parameter int FW = adc2s_pkg::ADC_F_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 c_vld,
  input  logic [CW-1:0]        c_code,
  input  logic [(1<<FW):0]     fine_raw,
  output logic                 f_vld_q,
  output logic [CW+FW-1:0]     f_code_q
);

  localparam int FN   = (1 << FW) - 1;
  localparam int FT   = FN + 2;
  localparam int OW   = CW + FW;
  localparam int OMAX = (1 << OW) - 1;

  logic [FT-1:0] ffix;
  logic [FN-1:0] mid_w;
  logic          under_w;
  logic          over_w;
  logic [FW-1:0] lsb_w;
  logic [OW-1:0] merged_w;

  adc2s_vote #(.N(FT)) vote_i (
    .raw   (fine_raw),
    .fixed (ffix)
  );

  function automatic logic [FW-1:0] top_one(input logic [FN-1:0] v);
    logic [FW-1:0] p;
    p = '0;
    for (int i = 0; i < FN; i++) begin
      if (v[i]) p = FW'(i + 1);
    end
    return p;
  endfunction

  function automatic logic [OW-1:0] merge_code(input logic [CW-1:0] c,
                                               input logic [FW-1:0] f,
                                               input logic un,
                                               input logic ov);
    int base;
    int r;
    base = int'(c) << FW;
    if (ov)      r = base + (1 << FW);
    else if (un) r = base - 1;
    else         r = base + int'(f);
    return OW'(adc2s_pkg::clamp_int(r, 0, OMAX));
  endfunction

  assign mid_w    = ffix[FT-2:1];
  assign under_w  = ~ffix[0];
  assign over_w   = ffix[FT-1];
  assign lsb_w    = top_one(mid_w);
  assign merged_w = merge_code(c_code, lsb_w, under_w, over_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      f_vld_q  <= 1'b0;
      f_code_q <= '0;
    end else begin
      f_vld_q <= c_vld;
      if (c_vld) f_code_q <= merged_w;
    end
  end

  // R8
  fine_follow_chk: assert property (@(posedge clk) disable iff (rst)
    c_vld |=> f_vld_q);

  // R8
  fine_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !c_vld |=> !f_vld_q);

  // R4
  inrange_msb_chk: assert property (@(posedge clk) disable iff (rst)
    c_vld && !under_w && !over_w |=> f_code_q[OW-1:FW] == $past(c_code));

  // R5
  under_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    c_vld && under_w && !over_w && c_code != '0 |=> f_code_q[FW-1:0] == '1);

  // R6
  over_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    c_vld && over_w && c_code != '1 |=> f_code_q[FW-1:0] == '0);

endmodule

// File: rtl/adc2s_merge.sv
module adc2s_merge #(
  parameter int OW = adc2s_pkg::ADC_C_BITS + adc2s_pkg::ADC_F_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_a,
  input  logic                start_b,
  output logic [1:0]          acc,
  input  logic [1:0]          f_vld,
  input  logic [1:0][OW-1:0]  f_code,
  output logic                smp_vld,
  output logic [OW-1:0]       smp_code,
  output logic                smp_chan
);

  import adc2s_pkg::*;

  adc_chan_e turn_q;
  logic      prev_q;
  logic      seen_q;

  assign acc[0] = start_a && (turn_q == CH_A);
  assign acc[1] = start_b && (turn_q == CH_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      turn_q   <= CH_A;
      smp_vld  <= 1'b0;
      smp_code <= '0;
      smp_chan <= 1'b0;
    end else begin
      if (|acc) turn_q <= (turn_q == CH_A) ? CH_B : CH_A;
      smp_vld  <= |f_vld;
      smp_code <= f_vld[1] ? f_code[1] : f_code[0];
      smp_chan <= f_vld[1];
    end
  end

  // verification-only record of the last emitted channel
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (smp_vld) begin
      prev_q <= smp_chan;
      seen_q <= 1'b1;
    end
  end

  // R7
  one_result_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(f_vld));

  // R9
  alternate_chk: assert property (@(posedge clk) disable iff (rst)
    smp_vld && seen_q |-> smp_chan != prev_q);

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !smp_vld);

endmodule

// File: rtl/adc2s_corr.sv
module adc2s_corr #(
  parameter int C_BITS = adc2s_pkg::ADC_C_BITS,
  parameter int F_BITS = adc2s_pkg::ADC_F_BITS
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_a,
  input  logic [(1<<C_BITS)-2:0]     crs_a,
  input  logic [(1<<F_BITS):0]       fin_a,
  input  logic                       start_b,
  input  logic [(1<<C_BITS)-2:0]     crs_b,
  input  logic [(1<<F_BITS):0]       fin_b,
  output logic [C_BITS-1:0]          fsel_a,
  output logic [C_BITS-1:0]          fsel_b,
  output logic                       smp_vld,
  output logic [C_BITS+F_BITS-1:0]   smp_code,
  output logic                       smp_chan
);

  localparam int CN = (1 << C_BITS) - 1;
  localparam int FT = (1 << F_BITS) + 1;
  localparam int OW = C_BITS + F_BITS;

  logic [1:0]              acc;
  logic [1:0]              c_vld;
  logic [1:0]              f_vld;
  logic [1:0][CN-1:0]      crs;
  logic [1:0][FT-1:0]      fin;
  logic [1:0][C_BITS-1:0]  csel;
  logic [1:0][OW-1:0]      fcode;

  assign crs[0] = crs_a;
  assign crs[1] = crs_b;
  assign fin[0] = fin_a;
  assign fin[1] = fin_b;
  assign fsel_a = csel[0];
  assign fsel_b = csel[1];

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    adc2s_coarse #(.CW(C_BITS)) crs_i (
      .clk     (clk),
      .rst     (rst),
      .acc     (acc[ch]),
      .th_raw  (crs[ch]),
      .c_vld_q (c_vld[ch]),
      .code_q  (csel[ch])
    );

    adc2s_fine #(.CW(C_BITS), .FW(F_BITS)) fin_i (
      .clk      (clk),
      .rst      (rst),
      .c_vld    (c_vld[ch]),
      .c_code   (csel[ch]),
      .fine_raw (fin[ch]),
      .f_vld_q  (f_vld[ch]),
      .f_code_q (fcode[ch])
    );
  end

  adc2s_merge #(.OW(OW)) mrg_i (
    .clk      (clk),
    .rst      (rst),
    .start_a  (start_a),
    .start_b  (start_b),
    .acc      (acc),
    .f_vld    (f_vld),
    .f_code   (fcode),
    .smp_vld  (smp_vld),
    .smp_code (smp_code),
    .smp_chan (smp_chan)
  );

endmodule

// File: tb/adc2s_corr_tb_top.sv
`timescale 1ns/1ps
module adc2s_corr_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_a = 1'b0, start_b = 1'b0;
  logic [14:0] crs_a = '0, crs_b = '0;
  logic [16:0] fin_a = '0, fin_b = '0;
  logic [3:0]  fsel_a, fsel_b;
  logic        smp_vld;
  logic [7:0]  smp_code;
  logic        smp_chan;

  always #4 clk = ~clk;

  adc2s_corr dut_i (
    .clk(clk), .rst(rst),
    .start_a(start_a), .crs_a(crs_a), .fin_a(fin_a),
    .start_b(start_b), .crs_b(crs_b), .fin_b(fin_b),
    .fsel_a(fsel_a), .fsel_b(fsel_b),
    .smp_vld(smp_vld), .smp_code(smp_code), .smp_chan(smp_chan)
  );

  int    nchk = 0, nfail = 0, cyc = 0;
  bit    done = 0;
  bit    turn = 0;
  int    ring_vld[4], ring_code[4], ring_chan[4];
  string ring_tag[4];
  bit    pend[2], pend_fb[2];
  int    pend_v[2], pend_cs[2], last_cs[2];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampv(input int v);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  function automatic int pick_coarse(input int v, input bit inj);
    int vc, c;
    vc = clampv(v);
    c  = vc / 16;
    if (inj && v >= 0 && v <= 255) begin
      if (vc % 16 == 0 && c > 0) c = c - 1;
      else if (vc % 16 == 15 && c < 15) c = c + 1;
    end
    return c;
  endfunction

  function automatic logic [14:0] coarse_word(input int c, input bit bub);
    logic [14:0] w;
    for (int j = 0; j < 15; j++) w[j] = (j < c);
    if (bub) begin
      for (int t = 0; t < 20; t++) begin
        int i;
        i = int'($urandom % 15);
        if (i <= c - 3 || i >= c + 2) begin
          w[i] = ~w[i];
          break;
        end
      end
    end
    return w;
  endfunction

  function automatic logic [16:0] fine_word(input int v, input int cs, input bit bub);
    logic [16:0] w;
    int n;
    n = 0;
    for (int j = 0; j < 17; j++) begin
      w[j] = (v >= cs * 16 + j);
      if (w[j]) n++;
    end
    if (bub) begin
      for (int t = 0; t < 20; t++) begin
        int i;
        i = int'($urandom % 17);
        if (i <= n - 3 || i >= n + 2) begin
          w[i] = ~w[i];
          break;
        end
      end
    end
    return w;
  endfunction

  task automatic step(input bit ga, input bit gb, input int va, input int vb,
                      input bit inj);
    int k, nk, cs, vsel, csel;
    bit cb, fb, acc_any;
    k = cyc % 4;
    if (ring_vld[k] != 0)
      chk(smp_vld === 1'b1 && int'(smp_code) == ring_code[k] && int'(smp_chan) == ring_chan[k],
          ring_tag[k], {smp_vld, smp_chan, smp_code},
          {1'b1, ring_chan[k][0], ring_code[k][7:0]});
    else
      chk(smp_vld === 1'b0, ring_tag[k], int'(smp_vld), 0);

    for (int ch = 0; ch < 2; ch++) begin
      cs = (ch == 0) ? int'(fsel_a) : int'(fsel_b);
      if (pend[ch]) begin
        chk(cs == pend_cs[ch], pend_fb[ch] ? "R2 fine select (R1 bubble)" : "R2 fine select",
            cs, pend_cs[ch]);
        if (ch == 0) fin_a = fine_word(pend_v[ch], cs, pend_fb[ch]);
        else         fin_b = fine_word(pend_v[ch], cs, pend_fb[ch]);
        pend[ch] = 1'b0;
      end else begin
        chk(cs == last_cs[ch], "R2 R7 select held", cs, last_cs[ch]);
        if (ch == 0) fin_a = 17'($urandom);
        else         fin_b = 17'($urandom);
      end
    end

    nk = (cyc + 3) % 4;
    ring_vld[nk] = 0;
    ring_tag[nk] = (ga || gb) ? "R7 ignored start" : "R8 idle";
    acc_any = (turn == 0) ? ga : gb;
    start_a = ga;
    start_b = gb;
    crs_a = 15'($urandom);
    crs_b = 15'($urandom);
    if (acc_any) begin
      vsel = (turn == 0) ? va : vb;
      cb   = inj && ($urandom % 2 == 0);
      fb   = inj && ($urandom % 2 == 0);
      csel = pick_coarse(vsel, inj);
      if (turn == 0) crs_a = coarse_word(csel, cb);
      else           crs_b = coarse_word(csel, cb);
      pend[turn]    = 1'b1;
      pend_v[turn]  = vsel;
      pend_cs[turn] = csel;
      pend_fb[turn] = fb;
      last_cs[turn] = csel;
      ring_vld[nk]  = 1;
      ring_code[nk] = clampv(vsel);
      ring_chan[nk] = int'(turn);
      ring_tag[nk]  = $sformatf("%s%s%s R8 R9",
                        (vsel < csel * 16) ? "R5" : (vsel >= csel * 16 + 16) ? "R6" : "R4",
                        cb ? " R1" : "", fb ? " R3" : "");
      turn = ~turn;
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic clear_model();
    for (int i = 0; i < 4; i++) begin
      ring_vld[i] = 0;
      ring_tag[i] = "R10 after reset";
    end
    for (int ch = 0; ch < 2; ch++) begin
      pend[ch] = 1'b0;
      last_cs[ch] = 0;
    end
    turn = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    start_a = 1'b0;
    start_b = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    clear_model();
    chk(smp_vld === 1'b0, "R10 valid cleared", int'(smp_vld), 0);
    chk(fsel_a == 4'd0 && fsel_b == 4'd0, "R10 selects cleared", {fsel_a, fsel_b}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog R8: actual=hung expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_2a17));
    clear_model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(smp_vld === 1'b0, "R10 reset valid", int'(smp_vld), 0);
    chk(fsel_a == 4'd0 && fsel_b == 4'd0, "R10 reset selects", {fsel_a, fsel_b}, 0);
    rst = 1'b0;

    // clean ramp, back to back, covers both clamping ends (R5 at -1, R6 at 256)
    for (int v = -1; v <= 256; v++) step(turn == 0, turn == 1, v, v, 1'b0);
    // ramp with bubbles and off-by-one coarse choices
    for (int v = -1; v <= 256; v++) step(turn == 0, turn == 1, v, v, 1'b1);

    // random mix: gaps, out-of-turn and simultaneous starts
    for (int n = 0; n < 700; n++) begin
      bit ga, gb;
      ga = ($urandom % 3 != 0);
      gb = ($urandom % 3 != 0);
      step(ga, gb, int'($urandom % 258) - 1, int'($urandom % 258) - 1,
           ($urandom % 2 == 0));
    end
    repeat (4) step(1'b0, 1'b0, 0, 0, 1'b0);

    // R7: out-of-turn B while turn is A is dropped
    step(turn == 1, turn == 0, 77, 150, 1'b0);
    repeat (4) step(1'b0, 1'b0, 0, 0, 1'b0);

    // R10: reset kills an in-flight conversion and returns the turn to A
    if (turn == 1) step(1'b0, 1'b1, 40, 40, 1'b0);
    step(1'b1, 1'b0, 200, 0, 1'b0);
    do_reset();
    step(1'b0, 1'b1, 0, 99, 1'b0);
    step(1'b1, 1'b0, 33, 0, 1'b0);
    step(1'b0, 1'b1, 0, 222, 1'b0);
    repeat (4) step(1'b0, 1'b0, 0, 0, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule